// File: doc/BRIEF.md
# Timed-Token Station Controller

This block is the token-holding logic of one station on a token-passing ring. All time is counted in clock cycles. When a token-arrival strobe is accepted, the station keeps the token for a fixed synchronous allocation of `SA` cycles. At the end of that hold it looks at how long the token took to come round since its previous accepted arrival. A late token is passed on at once. An early token opens an asynchronous window, and the station may keep the token in that window until the rotation time reaches the target `TRTT`.

Rotation is measured by two saturating counters that take turns. Each accepted arrival restarts the counter that is not in use. The counter in use was restarted by the previous accepted arrival, so it holds the rotation time to compare against `TRTT`. Every release flips which counter is in use. Framing, data movement and the ring itself are outside the block. A ring is built by connecting each station's release strobe to the next station's arrival input.

Top module: `tr_station_ctrl`

## Requirements
- R1: An accepted arrival sampled at clock edge a raises `sync_win_o` from edge a through edge a+SA-1, which is exactly SA cycles. No release and no asynchronous decision happen before edge a+SA.
- R2: Let p be the edge of the previous accepted arrival, or the last edge with reset low. If (a+SA)-p-1 ≥ TRTT, `tok_release_o` pulses in the cycle after edge a+SA and `async_win_o` never rises for this token.
- R3: If (a+SA)-p-1 < TRTT, `async_win_o` is high from edge a+SA. With the request held high, the release strobe follows edge p+TRTT+1, and the window never runs past that edge.
- R4: In the asynchronous window, if `async_req_i` is sampled low at an edge, the release strobe follows that edge. This gives an early release.
- R5: The two rotation counters alternate. An accepted arrival restarts only the counter not in use, and the counter in use is the one restarted by the previous accepted arrival. The in-use counter flips on every release.
- R6: Each accepted token produces exactly one release strobe, one cycle wide. After the release the station is idle in the other counter phase.
- R7: Rotation counters saturate at TRTT. An idle period longer than the counter's range still yields a late decision, with no wrap-around.
- R8: An arrival strobe sampled while the station is not idle pulses `proto_err_o` for one cycle after that edge. It otherwise has no effect: it restarts neither the hold nor a rotation counter.
- R9: After reset the station is idle in phase A, and `sync_win_o`, `async_win_o`, `tok_release_o` and `proto_err_o` are all low.
- R10: When six stations are chained in a ring with zero forwarding delay, the token circulates, and at most one station holds a sync or async window at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tok_arrive_i | input | 1 | Token-arrival strobe |
| async_req_i | input | 1 | Asynchronous traffic pending |
| tok_release_o | output | 1 | Token-release strobe, one cycle |
| sync_win_o | output | 1 | Synchronous hold in progress |
| async_win_o | output | 1 | Asynchronous window in progress |
| proto_err_o | output | 1 | Arrival seen while not idle, one-cycle pulse |

## Verification
All four outputs are registered. The window outputs change in the cycle after the deciding edge: arrival edge a for `sync_win_o`, and edge a+SA for the late-or-early decision. A release strobe is visible in the cycle after edge a+SA, after the sampled-low request edge, or after edge p+TRTT+1. The error pulse appears in the cycle after the offending arrival edge. The bench counts posedges and drives inputs at negedges. When it drives each token, it computes the release edge from the last accepted arrival edge and pushes that edge, together with whether an asynchronous window is due, into a scoreboard. A negedge monitor compares each strobe against the head of the queue in that same cycle and also measures the sync window length.

// File: rtl/tr_station_pkg.sv
// Shared types for the timed-token station controller.
// State encoding: bit 2 selects the rotation counter phase (0 = A, 1 = B),
// bits 1:0 hold the holding mode. Mode value 3 is unused.
package tr_station_pkg;

    typedef enum logic [1:0] {
        MODE_IDLE  = 2'd0,
        MODE_SYNC  = 2'd1,
        MODE_ASYNC = 2'd2
    } stn_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE_A  = 3'd0,
        ST_SYNC_A  = 3'd1,
        ST_ASYNC_A = 3'd2,
        ST_IDLE_B  = 3'd4,
        ST_SYNC_B  = 3'd5,
        ST_ASYNC_B = 3'd6
    } stn_state_e;

    // Holding mode part of a state.
    function automatic stn_mode_e mode_of(stn_state_e s);
        return stn_mode_e'(s[1:0]);
    endfunction

    // Counter phase part of a state.
    function automatic logic phase_of(stn_state_e s);
        return s[2];
    endfunction

    // Build a state from a phase and a mode.
    function automatic stn_state_e make_state(logic ph, stn_mode_e m);
        return stn_state_e'({ph, m});
    endfunction

endpackage

// File: rtl/tr_rot_timer.sv
// Rotation timer: counts clock cycles from its last restart and holds at
// LIMIT. Assumes LIMIT fits in W bits. Reset and restart both load zero.
module tr_rot_timer #(
    parameter int LIMIT = 320,
    parameter int W     = $clog2(LIMIT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    output logic expired_o
);
    localparam logic [W-1:0] CAP = W'(LIMIT);

    logic [W-1:0] cnt_q;

    // Saturating up-count, restarted on clr_i.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr_i) begin
            cnt_q <= '0;
        end else if (cnt_q != CAP) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Elapsed time has reached the target.
    assign expired_o = (cnt_q >= CAP);

    AST_ROT_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CAP);  // R7
    AST_ROT_HOLD_AT_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        (expired_o && !clr_i) |=> expired_o);  // R7

endmodule

// File: rtl/tr_hold_timer.sv
// Synchronous-hold timer: restarted by start_i, advances while run_i is high,
// and flags done_o in the last of HOLD cycles. Assumes HOLD >= 2.
module tr_hold_timer #(
    parameter int HOLD = 20,
    parameter int W    = $clog2(HOLD + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic run_i,
    output logic done_o
);
    localparam logic [W-1:0] LAST = W'(HOLD - 1);

    logic [W-1:0] hold_q;

    // Count cycles of the current synchronous hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else if (start_i) begin
            hold_q <= '0;
        end else if (run_i && hold_q != LAST) begin
            hold_q <= hold_q + 1'b1;
        end
    end

    // Final cycle of the hold.
    assign done_o = run_i && (hold_q == LAST);

    AST_HOLD_WITHIN_SA: assert property (@(posedge clk) disable iff (!rst_n)
        run_i |-> (hold_q <= LAST));  // R1

endmodule

// File: rtl/tr_station_fsm.sv
// Six-state token-holding controller. Decides when to take, keep and
// release the token, given the hold-done and rotation-expired flags from
// the timers. Assumes at most one arrival strobe per cycle.
module tr_station_fsm
    import tr_station_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic arrive_i,
    input  logic req_i,
    input  logic hold_done_i,
    input  logic rot_expired_i,
    output logic take_o,
    output logic phase_o,
    output logic in_sync_o,
    output logic in_async_o,
    output logic release_o,
    output logic err_o
);
    stn_state_e state_q, state_d;
    logic       rel_d;
    logic       idle;
    logic       release_q, err_q;

    assign idle = (mode_of(state_q) == MODE_IDLE);

    // Next-state and release decision.
    always_comb begin
        state_d = state_q;
        take_o  = 1'b0;
        rel_d   = 1'b0;
        unique case (mode_of(state_q))
            MODE_IDLE: begin
                if (arrive_i) begin
                    state_d = make_state(phase_of(state_q), MODE_SYNC);
                    take_o  = 1'b1;
                end
            end
            MODE_SYNC: begin
                if (hold_done_i) begin
                    if (rot_expired_i) begin
                        state_d = make_state(!phase_of(state_q), MODE_IDLE);
                        rel_d   = 1'b1;
                    end else begin
                        state_d = make_state(phase_of(state_q), MODE_ASYNC);
                    end
                end
            end
            MODE_ASYNC: begin
                if (!req_i || rot_expired_i) begin
                    state_d = make_state(!phase_of(state_q), MODE_IDLE);
                    rel_d   = 1'b1;
                end
            end
            default: state_d = ST_IDLE_A;
        endcase
    end

    // State, release strobe and protocol-error registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE_A;
            release_q <= 1'b0;
            err_q     <= 1'b0;
        end else begin
            state_q   <= state_d;
            release_q <= rel_d;
            err_q     <= arrive_i && !idle;
        end
    end

    assign phase_o    = phase_of(state_q);
    assign in_sync_o  = (mode_of(state_q) == MODE_SYNC);
    assign in_async_o = (mode_of(state_q) == MODE_ASYNC);
    assign release_o  = release_q;
    assign err_o      = err_q;

    AST_SYNC_HOLDS_UNTIL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_sync_o && !hold_done_i) |=> in_sync_o);  // R1
    AST_LATE_RELEASES_AT_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_sync_o && hold_done_i && rot_expired_i) |=> (release_o && !in_async_o));  // R2
    AST_EARLY_OPENS_ASYNC: assert property (@(posedge clk) disable iff (!rst_n)
        (in_sync_o && hold_done_i && !rot_expired_i) |=> in_async_o);  // R3
    AST_ASYNC_DEADLINE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_async_o && rot_expired_i) |=> (release_o && !in_async_o));  // R3
    AST_REQ_DROP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        (in_async_o && !req_i) |=> release_o);  // R4
    AST_PHASE_FLIPS_ON_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        release_o |-> (phase_o != $past(phase_o)));  // R5
    AST_SINGLE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        release_o |=> !release_o);  // R6
    AST_BUSY_ARRIVAL_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        (arrive_i && !idle) |=> err_o);  // R8

endmodule

// File: rtl/tr_station_ctrl.sv
// Top of the timed-token station controller. Joins the hold timer, the two
// alternating rotation timers and the state machine. SA is the synchronous
// hold in cycles (>= 2); TRTT is the target rotation time in cycles (> SA).
module tr_station_ctrl #(
    parameter int SA   = 20,
    parameter int TRTT = 320
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tok_arrive_i,
    input  logic async_req_i,
    output logic tok_release_o,
    output logic sync_win_o,
    output logic async_win_o,
    output logic proto_err_o
);
    localparam int HOLD_W  = $clog2(SA + 1);
    localparam int ROT_W   = $clog2(TRTT + 1);
    localparam int N_PHASE = 2;

    logic               take;
    logic               phase;
    logic               hold_done;
    logic [N_PHASE-1:0] rot_exp;
    logic               rot_expired;

    tr_hold_timer #(.HOLD(SA), .W(HOLD_W)) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (take),
        .run_i   (sync_win_o),
        .done_o  (hold_done)
    );

    // One rotation timer per phase; an accepted arrival restarts the idle one.
    for (genvar g = 0; g < N_PHASE; g++) begin : g_rot
        tr_rot_timer #(.LIMIT(TRTT), .W(ROT_W)) u_rot (
            .clk       (clk),
            .rst_n     (rst_n),
            .clr_i     (take && (phase != 1'(g))),
            .expired_o (rot_exp[g])
        );
    end

    // The timer of the current phase is the one examined.
    assign rot_expired = rot_exp[phase];

    tr_station_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .arrive_i      (tok_arrive_i),
        .req_i         (async_req_i),
        .hold_done_i   (hold_done),
        .rot_expired_i (rot_expired),
        .take_o        (take),
        .phase_o       (phase),
        .in_sync_o     (sync_win_o),
        .in_async_o    (async_win_o),
        .release_o     (tok_release_o),
        .err_o         (proto_err_o)
    );

    AST_TAKE_ONLY_WHEN_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> sync_win_o && !async_win_o);  // R1
    AST_NO_DUAL_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        !(sync_win_o && async_win_o));  // R6

endmodule

// File: tb/tb_tr_station_ctrl.sv
`timescale 1ns/1ps
module tb_tr_station_ctrl;
    localparam int SA   = 20;
    localparam int TRTT = 320;
    localparam int NST  = 6;

    typedef struct {
        int    rel_cyc;
        bit    async;
        string tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic arr = 1'b0;
    logic req = 1'b0;
    logic rel, sync_w, async_w, err;

    int   cyc = 0;
    int   nchk = 0;
    int   nfail = 0;
    int   p_last = 0;
    exp_t sb[$];

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    tr_station_ctrl #(.SA(SA), .TRTT(TRTT)) dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .tok_arrive_i  (arr),
        .async_req_i   (req),
        .tok_release_o (rel),
        .sync_win_o    (sync_w),
        .async_win_o   (async_w),
        .proto_err_o   (err)
    );

    // Six-station ring, release of one feeds arrival of the next.
    logic [NST-1:0] r_arr, r_rel, r_sync, r_async, r_err, r_req;
    logic kick = 1'b0;
    for (genvar gi = 0; gi < NST; gi++) begin : g_ring
        assign r_arr[gi] = r_rel[(gi + NST - 1) % NST] | ((gi == 0) ? kick : 1'b0);
        assign r_req[gi] = (gi % 2 == 0);
        tr_station_ctrl #(.SA(SA), .TRTT(TRTT)) u_st (
            .clk           (clk),
            .rst_n         (rst_n),
            .tok_arrive_i  (r_arr[gi]),
            .async_req_i   (r_req[gi]),
            .tok_release_o (r_rel[gi]),
            .sync_win_o    (r_sync[gi]),
            .async_win_o   (r_async[gi]),
            .proto_err_o   (r_err[gi])
        );
    end

    task automatic check(bit ok, string tag, int act, int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    endtask

    // Scoreboard monitor: compares each release against the queued expectation.
    int sync_len = 0;
    bit async_seen = 0;
    bit rel_prev = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (sync_w) sync_len++;
            if (async_w) async_seen = 1;
            if (rel) begin
                check(!rel_prev, "R6 strobe width", 2, 1);
                if (sb.size() == 0) begin
                    check(0, "R6 unexpected release", cyc, -1);
                end else begin
                    exp_t it;
                    it = sb.pop_front();
                    check(cyc == it.rel_cyc, it.tag, cyc, it.rel_cyc);
                    check(async_seen == it.async, {it.tag, " async window"}, int'(async_seen), int'(it.async));
                    check(sync_len == SA, "R1 sync length", sync_len, SA);
                end
                sync_len = 0;
                async_seen = 0;
            end
            rel_prev = rel;
        end
    end

    // Ring monitor.
    bit ring_on = 0;
    int rs_len[NST];
    int ra_len[NST];
    int ring_rel = 0;
    int overlap = 0;
    int ring_err = 0;
    always @(negedge clk) begin
        if (ring_on) begin
            if ($countones(r_sync | r_async) > 1) overlap++;
            if (r_err != '0) ring_err++;
            for (int i = 0; i < NST; i++) begin
                if (r_sync[i]) rs_len[i]++;
                if (r_async[i]) ra_len[i]++;
                if (r_rel[i]) begin
                    check(rs_len[i] == SA, "R10 ring sync length", rs_len[i], SA);
                    check(ra_len[i] < TRTT, "R3 ring async bound", ra_len[i], TRTT);
                    rs_len[i] = 0;
                    ra_len[i] = 0;
                    ring_rel++;
                end
            end
        end
    end

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    // Driver: present one token, push the expected release into the scoreboard.
    task automatic send_token(int at_edge, int drop, int err_ofs, string tag);
        int a, d, el, dl;
        exp_t it;
        if (at_edge > 0) while (cyc < at_edge - 1) @(negedge clk);
        req = (drop == 1) ? 1'b0 : 1'b1;
        arr = 1'b1;
        a = cyc + 1;
        @(negedge clk);
        arr = 1'b0;
        d  = a + SA;
        el = d - p_last - 1;
        it.tag = tag;
        if (el >= TRTT) begin
            it.rel_cyc = d;
            it.async = 0;
        end else begin
            dl = p_last + TRTT + 1;
            it.async = 1;
            it.rel_cyc = (drop > 0 && d + drop < dl) ? d + drop : dl;
        end
        sb.push_back(it);
        if (err_ofs > 0) begin
            while (cyc < a + err_ofs - 1) @(negedge clk);
            arr = 1'b1;
            @(negedge clk);
            arr = 1'b0;
            check(err == 1'b1, "R8 error pulse", int'(err), 1);
            @(negedge clk);
            check(err == 1'b0, "R8 error one cycle", int'(err), 0);
        end
        if (drop > 1) begin
            while (cyc < d + drop - 1) @(negedge clk);
            req = 1'b0;
        end
        while (sb.size() != 0) @(negedge clk);
        req = 1'b0;
        p_last = a;
    endtask

    initial begin
        idle(4);
        rst_n = 1'b1;
        p_last = cyc;
        idle(1);
        check(!sync_w && !async_w && !rel && !err, "R9 reset outputs",
              int'({sync_w, async_w, rel, err}), 0);
        idle(2);
        send_token(0, 0, 0, "R3 deadline release");
        send_token(0, 3, 0, "R2 late release");
        send_token(0, 3, 0, "R4 request drop");
        send_token(0, 1, 5, "R4 request low");
        idle(40);
        send_token(0, 0, 0, "R5 counter from last accepted arrival");
        idle(600);
        send_token(0, 0, 0, "R7 saturation late");
        send_token(p_last + TRTT + 1 - SA, 0, 0, "R2 boundary equal");
        send_token(p_last + TRTT - SA, 0, 0, "R3 boundary below");
        idle(3);
        ring_on = 1;
        kick = 1'b1;
        idle(1);
        kick = 1'b0;
        idle(4000);
        check(ring_rel >= 12, "R10 token circulates", ring_rel, 12);
        check(overlap == 0, "R10 single holder", overlap, 0);
        check(ring_err == 0, "R8 ring no error", ring_err, 0);
        finish_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        check(0, "watchdog", cyc, 0);
        finish_run();
    end

endmodule